// File: doc/BRIEF.md
# Byte-Wide SPI Port with Register Interface

This block is a full-duplex serial peripheral port that moves one byte at a time. Software sees three byte registers on a simple bus with separate read and write strobes: a control register, a status register and a data register. One control bit chooses the role. As the clock-generating side, the port derives its serial clock from the system clock through a programmable divider. It drives the outgoing data line and samples the incoming one. As the clocked side, it takes the serial clock and an active-low select from outside. It samples its input line and drives its output line only while it is selected.

Clock polarity and clock phase are both selectable, so all four serial modes are available. Either end of the byte can go first. The data register is shared by both directions: it holds the byte to send, and when a byte completes, that byte is replaced by the byte received. Completion raises a sticky flag and, when enabled, an interrupt request. A write to the data register while a byte is still moving is refused and flagged as a collision. In the clocked role the port synchronises the external clock and select into the system clock domain. Releasing the select part-way through a byte discards that byte.

Top module: `spi_port`

## Requirements
- R1: After reset the control, status and data registers read 0x00, `sck_out` is low and `irq` is low.
- R2: Offset 0 is control, with bit 7 interrupt enable, bit 6 port enable, bit 5 LSB-first, bit 4 master role, bit 3 polarity, bit 2 phase and bits 1:0 rate. It reads back as written. Offset 1 is status, with bit 7 completion flag, bit 6 collision flag, bits 5:1 reading 0 and bit 0 double speed. A status write changes only bit 0. Offset 2 is data.
- R3: In the master role, a data write with the port enabled and idle starts a byte. `sck_out` changes for the first time H cycles after the clock edge that captures the write, then every H cycles, for 16 changes in all. It rests at the polarity level whenever no byte is moving.
- R4: The half period H is 2, 8, 32 or 64 system cycles for rate values 0, 1, 2 and 3. With double speed set it is 1, 4, 16 or 32.
- R5: With LSB-first set, data bit 0 is shifted first. With it clear, bit 7 is shifted first.
- R6: With phase 0, bits are sampled on the leading SCK edge and changed on the trailing edge. With phase 1, bits are changed on the leading edge and sampled on the trailing edge. After a byte, the data register holds the byte received.
- R7: The completion flag becomes 1 on the clock edge of the final (16th) SCK change. `irq` is 1 while the flag and interrupt enable are both 1.
- R8: The completion flag stays set across a data register access that is not preceded by a status read that saw the flag set. It is cleared by a data register access after such a status read. It is also cleared by a one-cycle `irq_ack` pulse.
- R9: A data write while a byte is moving (or while selected in the slave role) sets the collision flag and leaves the data register unchanged. A subsequent data register read clears the collision flag.
- R10: In the slave role, while `ss_n_in` is low, the port shifts a byte in from `mosi_in` and out on `miso_out` per the mode bits. It then sets the completion flag and replaces the data register with the received byte.
- R11: If `ss_n_in` rises part-way through a byte in the slave role, that byte is dropped: the flag stays clear and the data register is unchanged. The next selection starts again from the first bit.
- R12: With the port enable clear, a data write starts no transfer: `sck_out` stays at the polarity level and no flag is set.
- R13: In the slave role with `ss_n_in` high, clock edges on `sck_in` do not transfer a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_rd | input | 1 | Read strobe; clear-on-access side effects occur on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Clears the completion flag |
| sck_in | input | 1 | Serial clock in the slave role |
| ss_n_in | input | 1 | Active-low select in the slave role |
| mosi_in | input | 1 | Serial data in the slave role |
| miso_in | input | 1 | Serial data in the master role |
| sck_out | output | 1 | Serial clock generated in the master role |
| mosi_out | output | 1 | Serial data out in the master role, 0 otherwise |
| miso_out | output | 1 | Serial data out in the slave role, 0 otherwise |

## Verification
In the master role every result is tied to the clock edge E that captures the data write. The first SCK change is due at E+H and the last at E+16H. The completion flag and interrupt are due on that same last edge. The bench counts cycles from E at falling edges, so it checks those exact cycles for every rate and double-speed setting. Register reads are combinational, and their clear-on-access effects land on the next rising edge, so flag clearing is checked one falling edge after each access. In the slave role the results trail each external SCK or select change by the synchroniser depth plus one register. The bench therefore holds each SCK half period for eight system cycles and samples `miso_out` and the flags only at the end of that window.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int HALF_W = 7;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd2;

    // control byte; field order is bit 7 down to bit 0
    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    // half of the SCK period in system cycles
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
        logic [HALF_W-1:0] base;
        case (rate)
            2'd0:    base = HALF_W'(2);
            2'd1:    base = HALF_W'(8);
            2'd2:    base = HALF_W'(32);
            default: base = HALF_W'(64);
        endcase
        return dbl ? (base >> 1) : base;
    endfunction
endpackage

// File: rtl/spi_port_clkdiv.sv
`timescale 1ns/1ps
module spi_port_clkdiv #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              lead,
    output logic              trail,
    output logic              phase
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              ph;
    } div_t;

    div_t div_q, div_d;

    always_comb begin
        div_d = div_q;
        lead  = 1'b0;
        trail = 1'b0;
        if (!run) begin
            div_d.cnt = '0;
            div_d.ph  = 1'b0;
        end else if (div_q.cnt == half - 1'b1) begin
            div_d.cnt = '0;
            div_d.ph  = ~div_q.ph;
            lead      = ~div_q.ph;
            trail     = div_q.ph;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign phase = div_q.ph;
endmodule

// File: rtl/spi_port_sync.sv
`timescale 1ns/1ps
module spi_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic ss_n_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic ss_n_s
);
    typedef struct packed {
        logic [STAGES-1:0] sck_sh;
        logic [STAGES-1:0] ss_sh;
        logic              sck_prev;
    } sync_t;

    sync_t sy_q, sy_d;
    logic  sck_s;

    assign sck_s  = sy_q.sck_sh[STAGES-1];
    assign ss_n_s = sy_q.ss_sh[STAGES-1];

    always_comb begin
        sy_d          = sy_q;
        sy_d.sck_sh   = {sy_q.sck_sh[STAGES-2:0], sck_in};
        sy_d.ss_sh    = {sy_q.ss_sh[STAGES-2:0], ss_n_in};
        sy_d.sck_prev = sck_s;
        sck_rise      = sck_s & ~sy_q.sck_prev;
        sck_fall      = ~sck_s & sy_q.sck_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.sck_sh   <= '0;
            sy_q.ss_sh    <= '1;
            sy_q.sck_prev <= 1'b0;
        end else begin
            sy_q <= sy_d;
        end
    end
endmodule

// File: rtl/spi_port_shift.sv
`timescale 1ns/1ps
module spi_port_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         lead,
    input  logic         trail,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         in_bit,
    input  logic [W-1:0] load_val,
    output logic         out_bit,
    output logic         active,
    output logic         done,
    output logic [W-1:0] rx_next
);
    localparam int CNT_W = $clog2(2 * W);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(2 * W - 1);

    typedef struct packed {
        logic [W-1:0]     sr;
        logic             hold;
        logic             obit;
        logic [CNT_W-1:0] cnt;
        logic             run;
    } sh_t;

    sh_t sh_q, sh_d;

    function automatic logic head(input logic [W-1:0] v, input logic lsb);
        return lsb ? v[0] : v[W-1];
    endfunction

    function automatic logic [W-1:0] push(input logic [W-1:0] v, input logic b, input logic lsb);
        return lsb ? {b, v[W-1:1]} : {v[W-2:0], b};
    endfunction

    always_comb begin
        sh_d = sh_q;
        done = 1'b0;
        if (abort) begin
            sh_d.run = 1'b0;
            sh_d.cnt = '0;
        end else if (start) begin
            sh_d.sr   = load_val;
            sh_d.cnt  = '0;
            sh_d.run  = 1'b1;
            sh_d.obit = head(load_val, lsb_first);
        end else if (sh_q.run && (lead || trail)) begin
            if (lead) begin
                if (cpha) sh_d.obit = head(sh_q.sr, lsb_first);
                else      sh_d.hold = in_bit;
            end else begin
                sh_d.sr = push(sh_q.sr, cpha ? in_bit : sh_q.hold, lsb_first);
            end
            if (sh_q.cnt == LAST_EDGE) begin
                sh_d.run = 1'b0;
                sh_d.cnt = '0;
                done     = 1'b1;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign out_bit = cpha ? sh_q.obit : head(sh_q.sr, lsb_first);
    assign active  = sh_q.run;
    assign rx_next = sh_d.sr;
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              irq_ack,
    input  logic              sck_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    input  logic              miso_in,
    output logic              sck_out,
    output logic              mosi_out,
    output logic              miso_out
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              dbl;
        logic              flag;
        logic              wcol;
        logic              arm;
        logic [BYTE_W-1:0] data;
    } regs_t;

    regs_t reg_q, reg_d;

    logic              en_q, master_q, cpol_q, flag_q, wcol_q;
    logic [BYTE_W-1:0] data_q;
    logic              wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
    logic              slave_sel, busy, m_start, s_start, start, abort;
    logic              m_lead, m_trail, m_phase, s_rise, s_fall, ss_s;
    logic              lead, trail, in_bit, out_bit, active, done;
    logic [BYTE_W-1:0] rx_next, load_val;
    logic [HALF_W-1:0] half;

    assign en_q     = reg_q.ctrl.enable;
    assign master_q = reg_q.ctrl.master;
    assign cpol_q   = reg_q.ctrl.cpol;
    assign flag_q   = reg_q.flag;
    assign wcol_q   = reg_q.wcol;
    assign data_q   = reg_q.data;

    assign wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
    assign wr_stat = bus_wr && bus_addr == OFS_STAT;
    assign wr_data = bus_wr && bus_addr == OFS_DATA;
    assign rd_stat = bus_rd && bus_addr == OFS_STAT;
    assign rd_data = bus_rd && bus_addr == OFS_DATA;

    assign slave_sel = en_q & ~master_q & ~ss_s;
    assign busy      = active | slave_sel;
    assign m_start   = wr_data & en_q & master_q & ~active;
    assign s_start   = slave_sel & ~active;
    assign start     = m_start | s_start;
    assign abort     = active & (~en_q | (~master_q & ss_s));
    assign load_val  = m_start ? bus_wdata : data_q;
    assign lead      = master_q ? m_lead  : (cpol_q ? s_fall : s_rise);
    assign trail     = master_q ? m_trail : (cpol_q ? s_rise : s_fall);
    assign in_bit    = master_q ? miso_in : mosi_in;
    assign half      = half_period(reg_q.ctrl.rate, reg_q.dbl);

    spi_port_clkdiv #(.HALF_W(HALF_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (master_q & active),
        .half  (half),
        .lead  (m_lead),
        .trail (m_trail),
        .phase (m_phase)
    );

    spi_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .ss_n_in  (ss_n_in),
        .sck_rise (s_rise),
        .sck_fall (s_fall),
        .ss_n_s   (ss_s)
    );

    spi_port_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .lead      (lead),
        .trail     (trail),
        .cpha      (reg_q.ctrl.cpha),
        .lsb_first (reg_q.ctrl.lsb_first),
        .in_bit    (in_bit),
        .load_val  (load_val),
        .out_bit   (out_bit),
        .active    (active),
        .done      (done),
        .rx_next   (rx_next)
    );

    always_comb begin
        reg_d = reg_q;
        if (wr_ctrl) reg_d.ctrl = ctrl_t'(bus_wdata);
        if (wr_stat) reg_d.dbl  = bus_wdata[0];
        if (rd_data) reg_d.wcol = 1'b0;
        if (wr_data) begin
            if (busy) reg_d.wcol = 1'b1;
            else      reg_d.data = bus_wdata;
        end
        if (rd_stat && reg_q.flag) reg_d.arm = 1'b1;
        if ((rd_data || wr_data) && reg_q.arm) begin
            reg_d.flag = 1'b0;
            reg_d.arm  = 1'b0;
        end
        if (irq_ack) reg_d.flag = 1'b0;
        if (done) begin
            reg_d.data = rx_next;
            reg_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = reg_q.ctrl;
            OFS_STAT: bus_rdata = {flag_q, wcol_q, 5'b0, reg_q.dbl};
            OFS_DATA: bus_rdata = data_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq      = flag_q & reg_q.ctrl.irq_en;
    assign sck_out  = cpol_q ^ m_phase;
    assign mosi_out = master_q ? out_bit : 1'b0;
    assign miso_out = master_q ? 1'b0 : out_bit;
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       master,
    input logic       cpol,
    input logic       sck_out,
    input logic       active,
    input logic       busy,
    input logic       done,
    input logic       flag,
    input logic       wcol,
    input logic [7:0] data,
    input logic       wr_data,
    input logic       irq_ack,
    input logic       ss_s
);
    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !active && $past(!active)) |-> sck_out == cpol);

    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(done));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done) |=> !flag);

    p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy) |=> wcol);

    p_data_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy && !done) |=> $stable(data));

    p_slave_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !master && ss_s) |-> !done);

    p_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active);
endmodule

bind spi_port spi_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .master  (master_q),
    .cpol    (cpol_q),
    .sck_out (sck_out),
    .active  (active),
    .busy    (busy),
    .done    (done),
    .flag    (flag_q),
    .wcol    (wcol_q),
    .data    (data_q),
    .wr_data (wr_data),
    .irq_ack (irq_ack),
    .ss_s    (ss_s)
);

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
    localparam int HS = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] addr;
    logic       wr, rd, ack;
    logic [7:0] wdata, rdata;
    logic       irq, sck_in, ss_n, mosi_in, miso_in, sck_out, mosi_out, miso_out;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .irq_ack(ack),
        .sck_in(sck_in), .ss_n_in(ss_n), .mosi_in(mosi_in), .miso_in(miso_in),
        .sck_out(sck_out), .mosi_out(mosi_out), .miso_out(miso_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #0.1; d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a; #0.1; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic pick(input logic [7:0] v, input int i, input logic lsb);
        return lsb ? v[i] : v[7-i];
    endfunction

    // master role: bench plays the far end
    task automatic mrun(input logic cpol, input logic cpha, input logic lsb, input logic [1:0] rate,
                        input logic dbl, input logic [7:0] tx, input logic [7:0] rx, input logic use_ack);
        int h, cyc, edges, bi;
        logic [7:0] got, v;
        logic prev;
        h = (rate == 2'd3) ? 64 : (2 << (2 * rate));
        if (dbl) h = h / 2;
        bwr(2'd0, {1'b1, 1'b1, lsb, 1'b1, cpol, cpha, rate});
        bwr(2'd1, {7'b0, dbl});
        bi = 0; got = '0;
        miso_in = pick(rx, 0, lsb);
        bwr(2'd2, tx);
        addr = 2'd1;
        chk("R3 sck at rest before first edge", sck_out, cpol);
        prev = sck_out; cyc = 0; edges = 0;
        while (edges < 16 && cyc < 20 * h + 20) begin
            @(negedge clk); cyc++;
            if (sck_out !== prev) begin
                prev = sck_out; edges++;
                if (edges == 1) chk("R4 first SCK change cycle", cyc, h);
                if (edges % 2 == 1) begin
                    if (cpha) miso_in = pick(rx, bi, lsb);
                    else begin
                        if (lsb) got[bi] = mosi_out; else got[7-bi] = mosi_out;
                    end
                end else begin
                    if (cpha) begin
                        if (lsb) got[bi] = mosi_out; else got[7-bi] = mosi_out;
                        bi++;
                    end else begin
                        bi++;
                        if (bi < 8) miso_in = pick(rx, bi, lsb);
                    end
                end
                if (edges == 16) begin
                    chk("R3 last SCK change cycle", cyc, 16 * h);
                    #0.1;
                    chk("R7 flag on last edge", rdata[7], 1);
                    chk("R7 irq with enable", irq, 1);
                end
            end
        end
        chk("R3 SCK change count", edges, 16);
        chk("R5 R6 bits seen on mosi", got, tx);
        chk("R3 sck back at rest", sck_out, cpol);
        brd(2'd2, v);
        chk("R6 received byte in data register", v, rx);
        peek(2'd1, v);
        chk("R8 flag kept without status read", v[7], 1);
        if (use_ack) begin
            @(negedge clk); ack = 1'b1;
            @(negedge clk); ack = 1'b0;
        end else begin
            brd(2'd1, v);
            brd(2'd2, v);
        end
        peek(2'd1, v);
        chk("R8 flag cleared", v[7], 0);
        chk("R8 irq cleared", irq, 0);
    endtask

    // slave role: bench plays the clocking end
    task automatic srun(input logic cpol, input logic cpha, input logic lsb,
                        input logic [7:0] tx, input logic [7:0] ry, input int cut);
        logic [7:0] got, v;
        got = '0;
        sck_in = cpol; ss_n = 1'b1;
        bwr(2'd0, {1'b1, 1'b1, lsb, 1'b0, cpol, cpha, 2'b00});
        bwr(2'd2, ry);
        ss_n = 1'b0;
        idle(HS);
        for (int i = 0; i < cut; i++) begin
            if (!cpha) begin
                mosi_in = pick(tx, i, lsb);
                idle(HS);
                if (lsb) got[i] = miso_out; else got[7-i] = miso_out;
                sck_in = ~sck_in;
                idle(HS);
                sck_in = ~sck_in;
            end else begin
                sck_in = ~sck_in;
                mosi_in = pick(tx, i, lsb);
                idle(HS);
                if (lsb) got[i] = miso_out; else got[7-i] = miso_out;
                sck_in = ~sck_in;
                idle(HS);
            end
        end
        idle(HS);
        if (cut < 8) begin
            ss_n = 1'b1;
            idle(2 * HS);
            peek(2'd1, v);
            chk("R11 no flag after dropped byte", v[7], 0);
            peek(2'd2, v);
            chk("R11 data kept after dropped byte", v, ry);
        end else begin
            chk("R10 bits seen on miso", got, ry);
            peek(2'd1, v);
            chk("R10 flag after slave byte", v[7], 1);
            peek(2'd2, v);
            chk("R10 received byte in data register", v, tx);
            ss_n = 1'b1;
            brd(2'd1, v);
            brd(2'd2, v);
            idle(HS);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [7:0] v;
        logic last;
        rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0; ack = 1'b0;
        sck_in = 1'b0; ss_n = 1'b1; mosi_in = 1'b0; miso_in = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        peek(2'd0, v); chk("R1 control after reset", v, 8'h00);
        peek(2'd1, v); chk("R1 status after reset", v, 8'h00);
        peek(2'd2, v); chk("R1 data after reset", v, 8'h00);
        chk("R1 sck after reset", sck_out, 0);
        chk("R1 irq after reset", irq, 0);

        bwr(2'd0, 8'h2D); peek(2'd0, v); chk("R2 control readback", v, 8'h2D);
        bwr(2'd1, 8'hFF); peek(2'd1, v); chk("R2 status write only bit 0", v, 8'h01);
        bwr(2'd1, 8'h00); peek(2'd1, v); chk("R2 status double speed clear", v, 8'h00);

        // port disabled, master role, polarity 1
        bwr(2'd0, 8'h98);
        bwr(2'd2, 8'h3C);
        last = sck_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck_out !== last) last = 1'bx;
        end
        chk("R12 sck quiet while disabled", last, 1);
        peek(2'd1, v); chk("R12 no flag while disabled", v[7], 0);

        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
                for (int d = 0; d < 2; d++)
                    mrun(m[1], m[0], l[0], 2'd0, d[0], 8'hA6 ^ 8'(m * 37 + l * 5 + d),
                         8'h39 ^ 8'(m * 11 + l * 64 + d * 3), l[0]);

        for (int r = 0; r < 4; r++)
            for (int d = 0; d < 2; d++)
                mrun(1'b0, 1'b0, 1'b0, r[1:0], d[0], 8'h96, 8'h4B, d[0]);

        // collision during a master byte
        miso_in = 1'b1;
        bwr(2'd0, 8'h52);
        bwr(2'd1, 8'h00);
        bwr(2'd2, 8'h5A);
        idle(10);
        bwr(2'd2, 8'hC3);
        peek(2'd1, v); chk("R9 collision flag set", v[6], 1);
        idle(16 * 32 + 4);
        brd(2'd2, v); chk("R9 data not overwritten by late write", v, 8'hFF);
        peek(2'd1, v); chk("R9 collision cleared by data read", v[6], 0);
        ack = 1'b1; @(negedge clk); ack = 1'b0;

        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
                srun(m[1], m[0], l[0], 8'hC5 ^ 8'(m * 29 + l), 8'h1E ^ 8'(m * 7 + l * 128), 8);

        srun(1'b0, 1'b0, 1'b0, 8'hF0, 8'h55, 3);
        srun(1'b0, 1'b0, 1'b0, 8'h81, 8'h7E, 8);

        // slave role, not selected
        bwr(2'd2, 8'h6B);
        ss_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            mosi_in = i[1];
            sck_in = ~sck_in;
            idle(HS);
        end
        idle(HS);
        peek(2'd1, v); chk("R13 no flag while deselected", v[7], 0);
        peek(2'd2, v); chk("R13 data kept while deselected", v, 8'h6B);

        report();
    end
endmodule